// File: doc/BRIEF.md
# Floating-Point Status and Trap Control

This block keeps the control and status word of a floating-point unit. The arithmetic datapath reports each finished operation with a strobe and five raw exception bits. The block turns that report into sticky status information. It also raises a trap request toward the core whenever an exception that software has enabled occurs. The same word drives two datapath controls: a rounding selector (truncate or round-to-nearest-even) and a flush-to-zero enable for denormal values.

Software loads the word through a plain write port, and only bits 18:0 can be written. Fields in the word:
- bits 1:0: rounding mode
- bits 6:2: flags, rebuilt after every operation
- bits 11:7: enables
- bits 17:12: accumulated causes
- bit 18: denormal flush

Exception bit k (0 = inexact, 1 = underflow, 2 = overflow, 3 = divide-by-zero, 4 = invalid) maps to flag bit 2+k, enable bit 7+k and cause bit 12+k.

Comparisons pass through the block too. An ordered comparison only sets the true/false result bit. An unordered comparison leaves that bit alone and updates the word as an ordinary operation would.

The trap controller is a two-state machine:
- **IDLE**: no request outstanding.
- **PENDING**: trap request high, with vector code 0x120 on the vector output.

It has two transitions:
- **RAISE** (IDLE to PENDING): taken when an accepted update hits an enabled cause.
- **ACK** (PENDING to IDLE): taken on the acknowledge input.

While the machine is in PENDING, operation strobes are dropped.

Top module: `fpsc_unit`

## Requirements
- R1: After reset, the word is 0, the result bit is 0, the trap request is low and the vector output is 0.
- R2: A write stores the write data ANDed with 0x0007FFFF, so bits 31:19 always read 0.
- R3: The rounding selector `rnd_trunc` is 1 exactly when word bits 1:0 equal 2'b01; every other value gives 0, meaning nearest-even.
- R4: `flush_en` follows word bit 18.
- R5: An accepted non-compare operation replaces flag bits 6:2 with `op_exc` (exc bit k goes to bit 2+k). All-zero exceptions therefore clear the flags.
- R6: The same operation ORs `op_exc` into cause bits 16:12 (exc bit k goes to bit 12+k). Enables, rounding mode, flush bit and cause bit 17 stay unchanged.
- R7: A trap is raised when an accepted update has a nonzero `op_exc` and some updated cause bit 12+k has its enable bit 7+k set. `trap_req` is then high in the next cycle with `trap_vec` = 0x120. Otherwise `trap_vec` is 0.
- R8: `trap_req` stays high until `trap_ack` is sampled high, and it is low in the cycle after that. `trap_ack` while idle has no effect.
- R9: While `trap_req` is high, operation strobes change neither the word nor the result bit.
- R10: An ordered compare (`op_is_cmp`=1, `cmp_unord`=0) loads `cmp_true` into `t_flag` and leaves the word unchanged.
- R11: An unordered compare leaves `t_flag` unchanged and updates the word and the trap as in R5 to R7.
- R12: When a write and an operation strobe occur in the same cycle, the write takes effect and the operation is discarded, with no trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_wr_en | input | 1 | Word write enable |
| csr_wdata | input | 32 | Word write data |
| op_valid | input | 1 | Operation-complete strobe |
| op_is_cmp | input | 1 | Strobe belongs to a comparison |
| cmp_unord | input | 1 | Comparison was unordered |
| cmp_true | input | 1 | Result of an ordered comparison |
| op_exc | input | 5 | Raw exceptions {invalid, div0, overflow, underflow, inexact} |
| trap_ack | input | 1 | Trap acknowledge |
| csr_q | output | 32 | Current word |
| rnd_trunc | output | 1 | 1 = truncate, 0 = nearest-even |
| flush_en | output | 1 | Denormal flush enable |
| t_flag | output | 1 | Comparison result bit |
| trap_req | output | 1 | FPU trap request |
| trap_vec | output | 12 | Vector code while requesting |

## Verification
Directed sequences cover the following cases:
- An all-ones write shows the mask.
- Each rounding code shows the selector decode.
- An operation with exceptions followed by one without shows that flags are rebuilt while causes are kept.
- A single enabled exception raises a trap, which is then held and acknowledged.
- An ordered compare is contrasted with an unordered one, which separates result-bit updates from word updates.

Random traffic from a fixed seed then mixes writes, operations, compares and acknowledges with random enables. This traffic exposes cases the directed runs miss: traps caused by earlier causes, operations dropped while a trap is pending, and write/operation collisions.

// File: rtl/fpsc_pkg.sv
package fpsc_pkg;
    localparam int EXC_W     = 5;
    localparam int RM_LSB    = 0;
    localparam int RM_W      = 2;
    localparam int FLAG_LSB  = 2;
    localparam int EN_LSB    = 7;
    localparam int CAUSE_LSB = 12;
    localparam int CAUSE_W   = 6;
    localparam int FLUSH_BIT = 18;
    localparam logic [RM_W-1:0] RM_TO_ZERO = 2'b01;

    typedef enum logic {
        ST_IDLE    = 1'b0,
        ST_PENDING = 1'b1
    } trap_state_e;
endpackage

// File: rtl/fpsc_ctl_decode.sv
module fpsc_ctl_decode
    import fpsc_pkg::*;
(
    input  logic [RM_W-1:0] rm,
    input  logic            dn,
    output logic            trunc,
    output logic            flush
);
    // Only the toward-zero code truncates; all others round to nearest-even.
    always_comb begin
        trunc = (rm == RM_TO_ZERO);
        flush = dn;
    end
endmodule

// File: rtl/fpsc_exc_merge.sv
module fpsc_exc_merge
    import fpsc_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] cur,
    input  logic [EXC_W-1:0]  exc,
    output logic [DATA_W-1:0] nxt,
    output logic              hit
);
    logic [EXC_W-1:0] cause_new;
    logic [EXC_W-1:0] match;

    // One lane per exception kind: accumulate cause, compare with enable.
    for (genvar gi = 0; gi < EXC_W; gi++) begin : g_lane
        assign cause_new[gi] = cur[CAUSE_LSB + gi] | exc[gi];
        assign match[gi]     = cause_new[gi] & cur[EN_LSB + gi];
    end

    always_comb begin
        nxt                       = cur;
        nxt[FLAG_LSB +: EXC_W]    = exc;
        nxt[CAUSE_LSB +: EXC_W]   = cause_new;
    end

    assign hit = (|exc) && (|match);
endmodule

// File: rtl/fpsc_trap_fsm.sv
module fpsc_trap_fsm
    import fpsc_pkg::*;
#(
    parameter int                VEC_W    = 12,
    parameter logic [VEC_W-1:0]  TRAP_VEC = 12'h120
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             raise,
    input  logic             ack,
    output logic             pending,
    output logic [VEC_W-1:0] vec
);
    trap_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (raise) state_d = ST_PENDING;   // RAISE
            ST_PENDING: if (ack)   state_d = ST_IDLE;      // ACK
            default:    state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        pending = 1'b0;
        vec     = '0;
        unique case (state_q)
            ST_IDLE:    ;
            ST_PENDING: begin
                pending = 1'b1;
                vec     = TRAP_VEC;
            end
            default:    ;
        endcase
    end

    // R7
    raise_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pending && raise) |=> pending);
    // R8
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !ack) |=> pending);
    // R8
    ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && ack) |=> !pending);
endmodule

// File: rtl/fpsc_unit.sv
module fpsc_unit
    import fpsc_pkg::*;
#(
    parameter int                DATA_W   = 32,
    parameter logic [DATA_W-1:0] WR_MASK  = 32'h0007_FFFF,
    parameter int                VEC_W    = 12,
    parameter logic [VEC_W-1:0]  TRAP_VEC = 12'h120
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csr_wr_en,
    input  logic [DATA_W-1:0] csr_wdata,
    input  logic              op_valid,
    input  logic              op_is_cmp,
    input  logic              cmp_unord,
    input  logic              cmp_true,
    input  logic [EXC_W-1:0]  op_exc,
    input  logic              trap_ack,
    output logic [DATA_W-1:0] csr_q,
    output logic              rnd_trunc,
    output logic              flush_en,
    output logic              t_flag,
    output logic              trap_req,
    output logic [VEC_W-1:0]  trap_vec
);
    logic [DATA_W-1:0] merged;
    logic              hit;
    logic              accept, upd_word, upd_t, raise;

    fpsc_exc_merge #(.DATA_W(DATA_W)) u_merge (
        .cur (csr_q),
        .exc (op_exc),
        .nxt (merged),
        .hit (hit)
    );

    fpsc_trap_fsm #(.VEC_W(VEC_W), .TRAP_VEC(TRAP_VEC)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .raise   (raise),
        .ack     (trap_ack),
        .pending (trap_req),
        .vec     (trap_vec)
    );

    fpsc_ctl_decode u_dec (
        .rm    (csr_q[RM_LSB +: RM_W]),
        .dn    (csr_q[FLUSH_BIT]),
        .trunc (rnd_trunc),
        .flush (flush_en)
    );

    always_comb begin
        accept   = op_valid && !trap_req && !csr_wr_en;
        upd_word = accept && (!op_is_cmp || cmp_unord);
        upd_t    = accept && op_is_cmp && !cmp_unord;
        raise    = upd_word && hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            csr_q  <= '0;
            t_flag <= 1'b0;
        end else begin
            if (csr_wr_en)     csr_q <= csr_wdata & WR_MASK;
            else if (upd_word) csr_q <= merged;
            if (upd_t)         t_flag <= cmp_true;
        end
    end

    // R9
    pend_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && !csr_wr_en) |=> $stable(csr_q));
    // R9
    pend_t_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |=> $stable(t_flag));
    // R10
    cmp_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_is_cmp && !cmp_unord && !csr_wr_en) |=> $stable(csr_q));
    // R6
    cause_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !csr_wr_en |=> ((csr_q[CAUSE_LSB +: CAUSE_W] & $past(csr_q[CAUSE_LSB +: CAUSE_W]))
                        == $past(csr_q[CAUSE_LSB +: CAUSE_W])));
    // R12
    wr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        csr_wr_en |=> (csr_q == ($past(csr_wdata) & WR_MASK)));
endmodule

// File: tb/fpsc_unit_test.sv
`timescale 1ns/1ps
module fpsc_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csr_wr_en = 1'b0;
    logic [31:0] csr_wdata = '0;
    logic        op_valid = 1'b0, op_is_cmp = 1'b0, cmp_unord = 1'b0, cmp_true = 1'b0;
    logic [4:0]  op_exc = '0;
    logic        trap_ack = 1'b0;
    logic [31:0] csr_q;
    logic        rnd_trunc, flush_en, t_flag, trap_req;
    logic [11:0] trap_vec;

    int tests = 0, fails = 0;
    bit done = 0;
    logic [31:0] m_csr = '0;
    logic        m_t = 1'b0, m_req = 1'b0;

    always #4 clk = ~clk;

    fpsc_unit uut (
        .clk(clk), .rst_n(rst_n), .csr_wr_en(csr_wr_en), .csr_wdata(csr_wdata),
        .op_valid(op_valid), .op_is_cmp(op_is_cmp), .cmp_unord(cmp_unord),
        .cmp_true(cmp_true), .op_exc(op_exc), .trap_ack(trap_ack),
        .csr_q(csr_q), .rnd_trunc(rnd_trunc), .flush_en(flush_en),
        .t_flag(t_flag), .trap_req(trap_req), .trap_vec(trap_vec)
    );

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic chk_all(input string tag);
        chk(tag, "csr_q", csr_q, m_csr);
        chk(tag, "t_flag", {31'd0, t_flag}, {31'd0, m_t});
        chk(tag, "trap_req", {31'd0, trap_req}, {31'd0, m_req});
        chk(tag, "trap_vec", {20'd0, trap_vec}, m_req ? 32'h120 : 32'h0);
        chk(tag, "rnd_trunc", {31'd0, rnd_trunc}, {31'd0, m_csr[1:0] == 2'b01});
        chk(tag, "flush_en", {31'd0, flush_en}, {31'd0, m_csr[18]});
    endtask

    // Drive one cycle, predict from the requirements, compare after the edge.
    task automatic step(input string tag, input logic wr, input logic [31:0] wd,
                        input logic opv, input logic cmp, input logic un, input logic ct,
                        input logic [4:0] ex, input logic ack);
        logic [31:0] n_csr;
        logic        n_t, n_req;
        logic [4:0]  cz;
        csr_wr_en = wr; csr_wdata = wd; op_valid = opv; op_is_cmp = cmp;
        cmp_unord = un; cmp_true = ct; op_exc = ex; trap_ack = ack;
        n_csr = m_csr; n_t = m_t; n_req = m_req;
        if (m_req && ack) n_req = 1'b0;                       // R8
        if (wr) n_csr = wd & 32'h0007_FFFF;                   // R2, R12
        else if (opv && !m_req) begin                         // R9
            if (cmp && !un) n_t = ct;                         // R10
            else begin                                        // R5, R6, R11
                cz = m_csr[16:12] | ex;
                n_csr[6:2]   = ex;
                n_csr[16:12] = cz;
                if (ex != 0 && (cz & m_csr[11:7]) != 0) n_req = 1'b1;   // R7
            end
        end
        @(posedge clk); #1;
        m_csr = n_csr; m_t = n_t; m_req = n_req;
        chk_all(tag);
        @(negedge clk);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk_all("R1");
        rst_n = 1'b1;
        @(negedge clk);
        chk_all("R1");

        // R2 mask, R4 flush, R3 decode of each rounding code
        step("R2", 1, 32'hFFFF_FFFF, 0, 0, 0, 0, 5'h0, 0);
        step("R3", 1, 32'h0000_0001, 0, 0, 0, 0, 5'h0, 0);
        step("R3", 1, 32'h0000_0002, 0, 0, 0, 0, 5'h0, 0);
        step("R4", 1, 32'h0004_0000, 0, 0, 0, 0, 5'h0, 0);
        // R5/R6 flags rebuilt, causes kept
        step("R2", 1, 32'h0, 0, 0, 0, 0, 5'h0, 0);
        step("R5", 0, 0, 1, 0, 0, 0, 5'b00101, 0);
        step("R5", 0, 0, 1, 0, 0, 0, 5'b00000, 0);
        step("R6", 0, 0, 1, 0, 0, 0, 5'b00010, 0);
        // R7 trap on enabled divide-by-zero
        step("R2", 1, 32'h0000_0400, 0, 0, 0, 0, 5'h0, 0);
        step("R8", 0, 0, 0, 0, 0, 0, 5'h0, 1);
        step("R7", 0, 0, 1, 0, 0, 0, 5'b01000, 0);
        step("R9", 0, 0, 1, 0, 0, 0, 5'b00001, 0);
        step("R9", 0, 0, 1, 1, 0, 1, 5'b00000, 0);
        step("R8", 0, 0, 0, 0, 0, 0, 5'h0, 0);
        step("R8", 0, 0, 0, 0, 0, 0, 5'h0, 1);
        // R10 ordered compare, R11 unordered compare
        step("R10", 0, 0, 1, 1, 0, 1, 5'h0, 0);
        step("R11", 0, 0, 1, 1, 1, 0, 5'b10000, 0);
        step("R10", 0, 0, 1, 1, 0, 0, 5'h0, 0);
        // R12 write wins over a trapping operation
        step("R12", 1, 32'h0000_0F80, 1, 0, 0, 0, 5'b11111, 0);
        step("R7", 0, 0, 1, 0, 0, 0, 5'b00001, 0);
        step("R8", 0, 0, 0, 0, 0, 0, 5'h0, 1);

        // Random traffic
        for (int i = 0; i < 4000; i++) begin
            logic wr, opv, cmp, un, ct, ack;
            logic [31:0] wd;
            logic [4:0] ex;
            string tag;
            wr  = ($urandom % 8) == 0;
            wd  = $urandom;
            opv = ($urandom % 3) != 0;
            cmp = ($urandom % 3) == 0;
            un  = $urandom % 2;
            ct  = $urandom % 2;
            ex  = (($urandom % 3) == 0) ? 5'h0 : 5'($urandom);
            ack = ($urandom % 4) == 0;
            if (wr)                 tag = opv ? "R12" : "R2";
            else if (m_req)         tag = opv ? "R9" : "R8";
            else if (opv && cmp && !un) tag = "R10";
            else if (opv && cmp)    tag = "R11";
            else if (opv)           tag = (ex != 0) ? "R7" : "R5";
            else                    tag = "R6";
            step(tag, wr, wd, opv, cmp, un, ct, ex, ack);
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule